// File: doc/BRIEF.md
# I2C Slave Read-Transfer Transmitter

This block is the sending half of an I2C slave during a host read. Once an address matcher reports that a read has begun, the block takes a byte from a one-entry transmit holding register and puts it on SDA one bit per SCL period, most significant bit first. It then lets go of SDA for the acknowledge slot and samples the host's answer. An ACK means the host wants more, so the block keeps ownership of the bus and loads the next byte on the following SCL falling edge. A NACK ends the read: the block releases SDA and parks. While parked it ignores further read starts until the bus shows a START or a STOP.

SCL and SDA arrive as raw samples and pass through a synchroniser chain before edge and condition detection. The block drives SDA through an open-drain enable: `sda_oe` high pulls the line low. Transmit bytes enter on a valid/ready stream. Status comes out as plain flags. These flags report that a byte was sent, the last acknowledge value, activity, and an underrun. There is also one interrupt request, gated by per-flag enables.

Top module: `i2cst_tx`

## Requirements
- R1: Each byte goes out most significant bit first. A 0 bit is sent with `sda_oe`=1 and a 1 bit with `sda_oe`=0. `sda_oe` only rises while SCL is low.
- R2: After the 8th data bit, `sda_oe` is 0 for the whole acknowledge slot. The acknowledge is sampled on the 9th SCL rising edge.
- R3: `flag_txd` sets when the acknowledge is sampled. It stays set until `status_clr` is pulsed, which clears `flag_txd`, `flag_nack` and `flag_underrun`.
- R4: `flag_nack` takes the sampled acknowledge value: 1 when SDA was high (NACK) and 0 when SDA was low (ACK).
- R5: `flag_busy` goes to 1 when a byte is loaded for sending and to 0 when its acknowledge is sampled.
- R6: After an ACK, the block keeps SDA ownership and loads the next byte on the next SCL falling edge, consuming the holding register.
- R7: After a NACK, `sda_oe` stays 0 and `rd_start` is ignored until a START or STOP is seen. After that, `rd_start` is accepted again.
- R8: If a byte is loaded while the holding register is empty, the previous byte is sent again and `flag_underrun` sets.
- R9: A START or STOP in the middle of a byte returns the block to idle with `sda_oe`=0 and `flag_busy`=0, without parking it.
- R10: `irq` is high exactly when (`flag_txd` and `ie_txd`) or (`flag_nack` and `ie_nack`).
- R11: Back-pressure works as follows. `tx_ready` is high while the holding register is empty. A byte is accepted on a cycle with `tx_valid` and `tx_ready`. `tx_ready` then stays low until that byte is consumed by a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL sample |
| sda_i | input | 1 | Raw SDA sample |
| rd_start | input | 1 | One-cycle pulse from the address matcher: a read begins (SCL low) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Transmit byte |
| tx_ready | output | 1 | Holding register empty |
| ie_txd | input | 1 | Interrupt enable for byte sent |
| ie_nack | input | 1 | Interrupt enable for NACK |
| status_clr | input | 1 | Pulse to clear the sent, NACK and underrun flags |
| sda_oe | output | 1 | SDA pull-low enable |
| flag_txd | output | 1 | Byte sent and acknowledge sampled |
| flag_nack | output | 1 | Last acknowledge was NACK |
| flag_busy | output | 1 | Byte in progress |
| flag_underrun | output | 1 | A byte was sent again because no new one was loaded |
| irq | output | 1 | Interrupt request |

## Verification
The bench plays the host on an open-drain bus model and goes after four corner cases. The first is a NACK followed by a fresh `rd_start` with no START or STOP in between. A design that does not park would grab the bus and take the queued byte. The second is a second byte with an empty holding register. A design that got this wrong would send stale zeros or forget the underrun flag. The third is a START raised in the middle of a byte; a design that mishandles it keeps driving or stays busy. The fourth is an ACK that follows a NACK, where a sticky NACK flag would show up. Interrupt gating is checked with one enable on and the other off, so an ungated or swapped enable is visible.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_ACK  = 2'd2,
    ST_HOLD = 2'd3
  } tx_state_e;
endpackage

// File: rtl/i2cst_bus_mon.sv
module i2cst_bus_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_sh[SYNC_STAGES-1];
  assign sda_lvl = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2cst_txbuf.sv
module i2cst_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              take,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_fresh
);
  logic              full;
  logic [DATA_W-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (tx_valid && !full) begin
        hold <= tx_data;
        full <= 1'b1;
      end
    end
  end

  assign tx_ready  = ~full;
  assign buf_data  = hold;
  assign buf_fresh = full;
endmodule

// File: rtl/i2cst_shifter.sv
module i2cst_shifter
  import i2cst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rd_start,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_fresh,
  output logic              take,
  output logic              sda_oe,
  output logic              ack_evt,
  output logic              ack_bit,
  output logic              underrun_evt,
  output logic              abort_evt
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              parked;
  logic              bus_cond;

  assign bus_cond = start_det | stop_det;
  assign take = !bus_cond &&
                ((state == ST_IDLE && rd_start && !parked) ||
                 (state == ST_HOLD && scl_fall));
  assign underrun_evt = take & ~buf_fresh;
  assign ack_evt      = !bus_cond && state == ST_ACK && scl_rise;
  assign ack_bit      = sda_lvl;
  assign abort_evt    = bus_cond && state != ST_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      parked <= 1'b0;
      sda_oe <= 1'b0;
    end else if (bus_cond) begin
      parked <= 1'b0;
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (take) begin
      shreg  <= buf_data;
      sda_oe <= ~buf_data[DATA_W-1];
      bitcnt <= '0;
      state  <= ST_SEND;
    end else begin
      case (state)
        ST_SEND: if (scl_fall) begin
          if (bitcnt == LAST) begin
            sda_oe <= 1'b0;
            state  <= ST_ACK;
          end else begin
            shreg  <= shreg << 1;
            sda_oe <= ~shreg[DATA_W-2];
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_ACK: if (scl_rise) begin
          if (sda_lvl) begin
            state  <= ST_IDLE;
            parked <= 1'b1;
          end else begin
            state  <= ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cst_status.sv
module i2cst_status (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic ack_evt,
  input  logic ack_bit,
  input  logic underrun_evt,
  input  logic abort_evt,
  input  logic status_clr,
  input  logic ie_txd,
  input  logic ie_nack,
  output logic flag_txd,
  output logic flag_nack,
  output logic flag_busy,
  output logic flag_underrun,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_txd      <= 1'b0;
      flag_nack     <= 1'b0;
      flag_busy     <= 1'b0;
      flag_underrun <= 1'b0;
    end else begin
      if (status_clr) begin
        flag_txd      <= 1'b0;
        flag_nack     <= 1'b0;
        flag_underrun <= 1'b0;
      end
      if (ack_evt) begin
        flag_txd  <= 1'b1;
        flag_nack <= ack_bit;
      end
      if (underrun_evt) flag_underrun <= 1'b1;
      if (load_evt) flag_busy <= 1'b1;
      else if (ack_evt || abort_evt) flag_busy <= 1'b0;
    end
  end

  assign irq = (flag_txd & ie_txd) | (flag_nack & ie_nack);
endmodule

// File: rtl/i2cst_tx.sv
module i2cst_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              rd_start,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              ie_txd,
  input  logic              ie_nack,
  input  logic              status_clr,
  output logic              sda_oe,
  output logic              flag_txd,
  output logic              flag_nack,
  output logic              flag_busy,
  output logic              flag_underrun,
  output logic              irq
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic take, buf_fresh, ack_evt, ack_bit, underrun_evt, abort_evt;
  logic [DATA_W-1:0] buf_data;

  i2cst_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2cst_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .take(take), .buf_data(buf_data), .buf_fresh(buf_fresh)
  );

  i2cst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_start(rd_start), .buf_data(buf_data), .buf_fresh(buf_fresh),
    .take(take), .sda_oe(sda_oe), .ack_evt(ack_evt), .ack_bit(ack_bit),
    .underrun_evt(underrun_evt), .abort_evt(abort_evt)
  );

  i2cst_status u_stat (
    .clk(clk), .rst_n(rst_n), .load_evt(take), .ack_evt(ack_evt),
    .ack_bit(ack_bit), .underrun_evt(underrun_evt), .abort_evt(abort_evt),
    .status_clr(status_clr), .ie_txd(ie_txd), .ie_nack(ie_nack),
    .flag_txd(flag_txd), .flag_nack(flag_nack), .flag_busy(flag_busy),
    .flag_underrun(flag_underrun), .irq(irq)
  );
endmodule

// File: rtl/i2cst_tx_checker.sv
module i2cst_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic tx_valid,
  input logic tx_ready,
  input logic sda_oe,
  input logic flag_txd,
  input logic flag_nack,
  input logic flag_busy,
  input logic irq
);
  assert_oe_rise_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_txd_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_txd) |-> !flag_busy);

  assert_nack_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_nack) |-> !sda_oe);

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_txd || flag_nack));

  assert_ready_fall_on_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid));
endmodule

bind i2cst_tx i2cst_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .sda_oe(sda_oe), .flag_txd(flag_txd),
  .flag_nack(flag_nack), .flag_busy(flag_busy), .irq(irq)
);

// File: tb/i2cst_tx_bench.sv
`timescale 1ns/1ps
module i2cst_tx_bench;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_host = 1'b1, sda_host = 1'b1;
  logic rd_start = 1'b0, tx_valid = 1'b0, status_clr = 1'b0;
  logic ie_txd = 1'b0, ie_nack = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, sda_oe, flag_txd, flag_nack, flag_busy, flag_underrun, irq;
  logic sda_line;
  int n_checks = 0, n_fail = 0;
  logic slot_oe, slot_txd, slot_nack, slot_busy;

  always #5 clk = ~clk;
  assign sda_line = sda_host & ~sda_oe;

  i2cst_tx u_i2cst_tx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_host), .sda_i(sda_line),
    .rd_start(rd_start), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .ie_txd(ie_txd), .ie_nack(ie_nack),
    .status_clr(status_clr), .sda_oe(sda_oe), .flag_txd(flag_txd),
    .flag_nack(flag_nack), .flag_busy(flag_busy),
    .flag_underrun(flag_underrun), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pulse_rd;
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic pulse_clr;
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
  endtask

  task automatic bus_start;
    sda_host = 1'b0; waitc(HALF);
    scl_host = 1'b0; waitc(HALF);
    sda_host = 1'b1; waitc(2);
  endtask

  task automatic bus_stop;
    sda_host = 1'b0; waitc(HALF);
    scl_host = 1'b1; waitc(HALF);
    sda_host = 1'b1; waitc(HALF);
  endtask

  task automatic host_read_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      waitc(HALF); scl_host = 1'b1;
      waitc(HALF/2); d[i] = sda_line;
      waitc(HALF/2); scl_host = 1'b0;
    end
    waitc(2); sda_host = nack;
    waitc(HALF-2); scl_host = 1'b1;
    waitc(HALF/2);
    slot_oe = sda_oe; slot_txd = flag_txd; slot_nack = flag_nack; slot_busy = flag_busy;
    waitc(HALF/2); scl_host = 1'b0;
    waitc(2); sda_host = 1'b1;
  endtask

  task automatic t_reset;
    check("R11 reset tx_ready", tx_ready, 1);
    check("R1 reset sda_oe", sda_oe, 0);
    check("R5 reset busy", flag_busy, 0);
    check("R3 reset txd", flag_txd, 0);
    check("R10 reset irq", irq, 0);
  endtask

  task automatic t_ack_then_nack;
    logic [7:0] d;
    ie_txd = 1'b0; ie_nack = 1'b1;
    bus_start();
    push(8'hA5);
    check("R11 ready low when full", tx_ready, 0);
    pulse_rd();
    check("R11 ready after consume", tx_ready, 1);
    check("R5 busy on load", flag_busy, 1);
    check("R1 first bit drive (A5 msb=1)", sda_oe, 0);
    push(8'h3C);
    host_read_byte(1'b0, d);
    check("R1 byte0 MSB first", d, 8'hA5);
    check("R2 released in ack slot", slot_oe, 0);
    check("R3 txd after ack", slot_txd, 1);
    check("R4 nack clear on ACK", slot_nack, 0);
    check("R5 busy clear at ack", slot_busy, 0);
    check("R10 irq gated by ie_txd=0", irq, 0);
    host_read_byte(1'b1, d);
    check("R6 next byte after ACK", d, 8'h3C);
    check("R4 nack set on NACK", slot_nack, 1);
    check("R10 irq from nack", irq, 1);
    check("R8 no underrun", flag_underrun, 0);
    waitc(4);
    check("R7 released after NACK", sda_oe, 0);
    pulse_clr();
    check("R3 clr txd", flag_txd, 0);
    check("R3 clr nack irq", irq, 0);
    bus_stop();
  endtask

  task automatic t_parked;
    logic [7:0] d;
    bus_start();
    push(8'h5A);
    pulse_rd();
    host_read_byte(1'b1, d);
    check("R1 byte 5A", d, 8'h5A);
    push(8'h77);
    pulse_rd();
    waitc(4);
    check("R7 rd_start ignored busy", flag_busy, 0);
    check("R7 rd_start ignored ready", tx_ready, 0);
    check("R7 rd_start ignored oe", sda_oe, 0);
    bus_stop();
    bus_start();
    pulse_rd();
    check("R7 accepted after STOP", flag_busy, 1);
    host_read_byte(1'b0, d);
    check("R7 byte after unpark", d, 8'h77);
    check("R4 ACK after earlier NACK clears", slot_nack, 0);
    host_read_byte(1'b1, d);
    check("R8 underrun resends previous", d, 8'h77);
    check("R8 underrun flag", flag_underrun, 1);
    ie_txd = 1'b1; ie_nack = 1'b0;
    waitc(1);
    check("R10 irq from txd enable", irq, 1);
    ie_txd = 1'b0;
    waitc(1);
    check("R10 irq off with both disabled", irq, 0);
    pulse_clr();
    check("R3 clr underrun", flag_underrun, 0);
    bus_stop();
  endtask

  task automatic t_abort;
    logic [7:0] d;
    bus_start();
    push(8'hFF);
    pulse_rd();
    for (int i = 0; i < 3; i++) begin
      waitc(HALF); scl_host = 1'b1;
      waitc(HALF); scl_host = 1'b0;
    end
    waitc(HALF); scl_host = 1'b1;
    waitc(HALF/2); sda_host = 1'b0;
    waitc(HALF/2);
    check("R9 abort busy", flag_busy, 0);
    check("R9 abort oe", sda_oe, 0);
    check("R3 abort no txd", flag_txd, 0);
    scl_host = 1'b0; waitc(HALF);
    sda_host = 1'b1; waitc(2);
    push(8'h0F);
    pulse_rd();
    check("R9 not parked after abort", flag_busy, 1);
    host_read_byte(1'b1, d);
    check("R9 byte after abort", d, 8'h0F);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    waitc(4);
    rst_n = 1'b1;
    waitc(4);
    t_reset();
    t_ack_then_nack();
    t_parked();
    t_abort();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule